// File: doc/BRIEF.md
# Split-Section Binary Ripple Counter

This block is a four-bit binary counter made of two sections that can work alone or together. The lower section is one toggle stage that divides its own count input by two. The upper section is a chain of three toggle stages that divides its own count input by eight. Every stage advances on a high-to-low transition of whatever drives it. The two count inputs are asynchronous strobes. A free-running system clock samples them through synchronizers, and a falling edge becomes a single-cycle tick.

A chain-enable input joins the two sections. When it is high, the falling output of the lower stage drives the upper section. The block then counts falling edges of the lower count input modulo 16. When it is low, the sections count apart. The upper section takes its ticks from its own input, and the lower stage can serve as a separate divide-by-two.

Carries ripple one system clock per stage, so the output bits settle in order from the lowest bit to the highest. A clear resets every stage, every synchronizer and every edge detector. It is asynchronous and acts only while both clear inputs are high.

Top module: `split_ripple_counter`

## Requirements
- R1: The clear acts only while `clr_a` and `clr_b` are both high; with only one of them high the count is kept and counting goes on.
- R2: The clear is asynchronous: `q` reads 4'b0000 as soon as both clear inputs are high, without waiting for a clock edge, and stays zero while they remain high.
- R3: `q[0]` toggles once for each high-to-low transition of `cnt_lo`; a low-to-high transition leaves `q` unchanged.
- R4: With `chain_en` low, `q[3:1]` is a 3-bit binary count (bit 1 least significant) of high-to-low transitions of `cnt_hi`, wrapping from 7 to 0.
- R5: With `chain_en` high, `q[3:0]` is a 4-bit binary count (bit 0 least significant) of high-to-low transitions of `cnt_lo`, wrapping from 15 to 0.
- R6: With `chain_en` high, transitions of `cnt_hi` have no effect on `q`.
- R7: With `chain_en` low, a 1-to-0 change of `q[0]` does not advance `q[3:1]`, and `cnt_hi` does not change `q[0]`.
- R8: A carry moves one system clock per stage: in chained mode the step from 15 shows `q` as 14, 12, 8 and then 0 on consecutive clock cycles.
- R9: A count input that falls while the clear is active produces no count after the clear is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock that samples the count inputs |
| clr_a | input | 1 | First clear input, active high, ANDed with `clr_b` |
| clr_b | input | 1 | Second clear input, active high, ANDed with `clr_a` |
| chain_en | input | 1 | High: lower stage drives the upper section; low: sections independent |
| cnt_lo | input | 1 | Count input of the divide-by-two section, falling-edge active |
| cnt_hi | input | 1 | Count input of the divide-by-eight section, falling-edge active |
| q | output | 4 | Stage outputs, bit 0 = lower section, bits 3:1 = upper section |

## Verification
The assertions assume that the count inputs stay at each level for at least two system clocks. They also assume that falling edges on one count input are spaced well beyond the four-cycle ripple time, so that a new tick never enters a stage while an earlier carry is still moving. They further assume that `chain_en` only changes while the counter is idle. The stimulus holds each level of a count strobe for four cycles and then waits ten cycles after each falling edge. It sets `chain_en` only straight after a clear, and it keeps both clear inputs high across several clock edges whenever it clears.

// File: rtl/split_cnt_pkg.sv
package split_cnt_pkg;

    localparam int LO_W    = 1;
    localparam int UP_W    = 3;
    localparam int TOTAL_W = LO_W + UP_W;
    localparam int SYNC_N  = 2;
    localparam int N_INPUTS = 2;

    typedef logic [TOTAL_W-1:0] count_t;

    typedef enum logic {
        SRC_SPLIT = 1'b0,
        SRC_CHAIN = 1'b1
    } up_src_e;

    typedef struct packed {
        logic q;
        logic carry;
    } stage_s;

    function automatic logic is_fall(input logic prev, input logic cur);
        return prev & ~cur;
    endfunction

endpackage

// File: rtl/fall_detect.sv
module fall_detect #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic clr,
    input  logic din,
    output logic fall
);
    import split_cnt_pkg::*;

    localparam int PIPE_W = SYNC_N + 1;

    logic [PIPE_W-1:0] pipe;

    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            pipe <= '0;
        end else begin
            pipe <= {pipe[PIPE_W-2:0], din};
        end
    end

    assign fall = is_fall(pipe[PIPE_W-1], pipe[PIPE_W-2]);

    // R3
    fall_pulse_chk: assert property (@(posedge clk) disable iff (clr)
        fall |=> !fall);

endmodule

// File: rtl/toggle_stage.sv
module toggle_stage (
    input  logic clk,
    input  logic clr,
    input  logic tick,
    output logic q,
    output logic carry
);
    import split_cnt_pkg::*;

    stage_s st;

    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            st <= '0;
        end else begin
            st.q     <= st.q ^ tick;
            st.carry <= tick & st.q;
        end
    end

    assign q     = st.q;
    assign carry = st.carry;

    // R3
    stage_hold_chk: assert property (@(posedge clk) disable iff (clr)
        !tick |=> $stable(q));

    // R8
    carry_pulse_chk: assert property (@(posedge clk) disable iff (clr)
        carry |=> !carry);

endmodule

// File: rtl/split_ripple_counter.sv
module split_ripple_counter
    import split_cnt_pkg::*;
(
    input  logic         clk,
    input  logic         clr_a,
    input  logic         clr_b,
    input  logic         chain_en,
    input  logic         cnt_lo,
    input  logic         cnt_hi,
    output logic [3:0]   q
);

    localparam int TOP = TOTAL_W - 1;

    logic                clr;
    logic [N_INPUTS-1:0] raw_in;
    logic [N_INPUTS-1:0] fall;
    logic [TOTAL_W-1:0]  tick;
    logic [TOTAL_W-1:0]  carry;
    count_t              cnt;
    up_src_e             up_src;

    assign clr    = clr_a & clr_b;
    assign raw_in = {cnt_hi, cnt_lo};
    assign up_src = chain_en ? SRC_CHAIN : SRC_SPLIT;

    for (genvar i = 0; i < N_INPUTS; i++) begin : g_in
        fall_detect #(.SYNC_N(SYNC_N)) u_fall (
            .clk  (clk),
            .clr  (clr),
            .din  (raw_in[i]),
            .fall (fall[i])
        );
    end

    for (genvar s = 0; s < TOTAL_W; s++) begin : g_stage
        if (s == 0) begin : g_lo
            assign tick[s] = fall[0];
        end else if (s == LO_W) begin : g_link
            always_comb begin
                case (up_src)
                    SRC_CHAIN: tick[s] = carry[LO_W-1];
                    default:   tick[s] = fall[1];
                endcase
            end
        end else begin : g_ripple
            assign tick[s] = carry[s-1];
        end

        toggle_stage u_stage (
            .clk   (clk),
            .clr   (clr),
            .tick  (tick[s]),
            .q     (cnt[s]),
            .carry (carry[s])
        );
    end

    assign q = cnt;

    // R6
    chain_iso_chk: assert property (@(posedge clk) disable iff (clr)
        (chain_en && !carry[0]) |=> $stable(q[1]));

    // R7
    split_iso_chk: assert property (@(posedge clk) disable iff (clr)
        (!chain_en && !fall[1]) |=> $stable(q[1]));

    // R4
    wrap_zero_chk: assert property (@(posedge clk) disable iff (clr)
        carry[TOP] |-> (q[TOP:LO_W] == '0));

endmodule

// File: tb/split_ripple_counter_tb.sv
`timescale 1ns/1ps
module split_ripple_counter_tb;

    logic       clk = 1'b0;
    logic       clr_a = 1'b0;
    logic       clr_b = 1'b0;
    logic       chain_en = 1'b0;
    logic       cnt_lo = 1'b0;
    logic       cnt_hi = 1'b0;
    logic [3:0] q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    split_ripple_counter u_dut (
        .clk      (clk),
        .clr_a    (clr_a),
        .clr_b    (clr_b),
        .chain_en (chain_en),
        .cnt_lo   (cnt_lo),
        .cnt_hi   (cnt_hi),
        .q        (q)
    );

    // fields: [13] chain, [12:8] lo falls, [7:4] hi falls, [3:0] expected q
    localparam logic [13:0] VEC [7] = '{
        {1'b0, 5'd1,  4'd0, 4'b0001},   // R3
        {1'b0, 5'd2,  4'd3, 4'b0110},   // R4 R7
        {1'b0, 5'd3,  4'd9, 4'b0011},   // R4 wrap
        {1'b0, 5'd0,  4'd7, 4'b1110},   // R4
        {1'b1, 5'd5,  4'd0, 4'b0101},   // R5
        {1'b1, 5'd11, 4'd4, 4'b1011},   // R6
        {1'b1, 5'd17, 4'd0, 4'b0001}    // R5 wrap
    };

    task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s q=%b expected=%b", req, got, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr_a = 1'b1;
        clr_b = 1'b1;
        wait_cyc(3);
        clr_a = 1'b0;
        clr_b = 1'b0;
        wait_cyc(2);
    endtask

    task automatic pulse(input bit hi_side);
        if (hi_side) cnt_hi = 1'b1; else cnt_lo = 1'b1;
        wait_cyc(4);
        if (hi_side) cnt_hi = 1'b0; else cnt_lo = 1'b0;
        wait_cyc(10);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog q=%b expected=run end", q);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [3:0] seen;
        // reset state, R2
        do_clear();
        check("R2 reset state", q, 4'b0000);

        // vector table
        for (int v = 0; v < 7; v++) begin
            do_clear();
            chain_en = VEC[v][13];
            for (int k = 0; k < int'(VEC[v][12:8]); k++) pulse(1'b0);
            for (int k = 0; k < int'(VEC[v][7:4]); k++) pulse(1'b1);
            check($sformatf("R3-vector %0d", v), q, VEC[v][3:0]);
        end

        // R3: rising edge alone has no effect
        do_clear();
        chain_en = 1'b0;
        cnt_lo = 1'b1;
        wait_cyc(8);
        check("R3 rising edge ignored", q, 4'b0000);
        cnt_lo = 1'b0;
        wait_cyc(10);
        check("R3 falling edge counts", q, 4'b0001);

        // R7: lower stage 1->0 does not advance upper in split mode
        pulse(1'b0);
        check("R7 split isolation", q, 4'b0000);

        // R1: single clear input does not clear
        do_clear();
        chain_en = 1'b1;
        for (int k = 0; k < 3; k++) pulse(1'b0);
        clr_a = 1'b1;
        wait_cyc(4);
        check("R1 clr_a alone", q, 4'b0011);
        pulse(1'b0);
        check("R1 counting under clr_a", q, 4'b0100);
        clr_a = 1'b0;
        clr_b = 1'b1;
        wait_cyc(4);
        check("R1 clr_b alone", q, 4'b0100);
        clr_b = 1'b0;

        // R2: asynchronous clear, seen before the next rising edge
        @(negedge clk);
        clr_a = 1'b1;
        clr_b = 1'b1;
        #1;
        check("R2 async clear", q, 4'b0000);
        wait_cyc(3);
        check("R2 clear held", q, 4'b0000);
        clr_a = 1'b0;
        clr_b = 1'b0;
        wait_cyc(2);

        // R8: ripple order from 15
        chain_en = 1'b1;
        for (int k = 0; k < 15; k++) pulse(1'b0);
        check("R8 preload 15", q, 4'b1111);
        cnt_lo = 1'b1;
        wait_cyc(4);
        cnt_lo = 1'b0;
        seen = q;
        for (int k = 0; k < 20 && seen == 4'b1111; k++) begin
            @(negedge clk);
            seen = q;
        end
        check("R8 step 1", seen, 4'b1110);
        @(negedge clk);
        check("R8 step 2", q, 4'b1100);
        @(negedge clk);
        check("R8 step 3", q, 4'b1000);
        @(negedge clk);
        check("R8 step 4", q, 4'b0000);

        // R9: fall during clear gives no count after release
        do_clear();
        chain_en = 1'b1;
        cnt_lo = 1'b1;
        wait_cyc(4);
        clr_a = 1'b1;
        clr_b = 1'b1;
        wait_cyc(2);
        cnt_lo = 1'b0;
        wait_cyc(3);
        clr_a = 1'b0;
        clr_b = 1'b0;
        wait_cyc(10);
        check("R9 no false edge", q, 4'b0000);
        pulse(1'b0);
        check("R9 counts after release", q, 4'b0001);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule